// File: doc/BRIEF.md
# Map Fault Type Resolver

This block runs after a memory map fault or a stack error has been taken from the emulator. It chooses the trap to raise. The three possible traps are stack error, page fault and write-protect fault. It also builds the fault parameter pair from the faulting virtual address and produces a repaired stack pointer. Trap delivery and queueing are handled elsewhere.

A single `start` pulse is accepted only while the block is idle. At that pulse the block captures its inputs and decides the result. It then holds the instruction-fetch unit in reset for a fixed countdown, which clears any pending break byte. After the countdown it raises `done` for one cycle. The trap code, the parameters and the stack pointer are valid together with `done`, and they stay unchanged until the next accepted `start`.

Stack problems win over map faults. The stack pointer is out of bounds when its value is greater than the stack size. The upper four bits of the address high half are known to read back as ones. Only the low 12 bits of that half are kept.

Top module: `mfr_top`

## Requirements
- R1: After reset, `busy`, `done` and `fetch_rst` are 0 and `trap_code` is 0 (none).
- R2: With no stack error, `trap_code` is 2 (write-protect) exactly when `wp_bit`=1, `dirty_bit`=0 and `was_store`=1.
- R3: With no stack error, every other combination of `wp_bit`, `dirty_bit` and `was_store` gives `trap_code` 1 (page fault).
- R4: When either `stk_over` or `stk_under` is 1, `trap_code` is 3 (stack error), whatever the map bits are.
- R5: When `cur_sp` is greater than STACK_SIZE (default 14), `trap_code` is 3 even with both stack flags at 0. A value equal to STACK_SIZE is in bounds.
- R6: On a stack error with `start_sp` at most STACK_SIZE, `sp_out` equals `start_sp`.
- R7: On a stack error with `start_sp` greater than STACK_SIZE, `sp_out` equals STACK_SIZE.
- R8: On a page fault or a write-protect fault, `sp_out` equals `cur_sp`.
- R9: `param_lo` equals `va_lo`. `param_hi` equals bits 11:0 of `va_hi`, with bits 15:12 forced to 0.
- R10: `fetch_rst` is 1 for exactly RST_CYCLES cycles (default 40, octal 50), starting in the cycle after `start` is accepted. `done` is 1 for exactly one cycle, the cycle right after `fetch_rst` falls.
- R11: A `start` pulse while `busy` is 1 is ignored. The results and the countdown length of the operation in progress are not changed.
- R12: After `done`, the outputs keep their values while the inputs change, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving; honoured only when idle |
| wp_bit | input | 1 | Map entry is write-protected |
| dirty_bit | input | 1 | Map entry is dirty |
| was_store | input | 1 | Faulting reference was a store |
| stk_over | input | 1 | Stack overflow flag |
| stk_under | input | 1 | Stack underflow flag |
| cur_sp | input | SP_W | Stack pointer at time of fault |
| start_sp | input | SP_W | Stack pointer at instruction start |
| va_hi | input | VA_W | Virtual address high half |
| va_lo | input | VA_W | Virtual address low half |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid strobe |
| fetch_rst | output | 1 | Reset held on the fetch unit |
| trap_code | output | 2 | 0 none, 1 page, 2 write-protect, 3 stack error |
| param_lo | output | VA_W | Fault parameter, low address half |
| param_hi | output | VA_W | Fault parameter, masked high half |
| sp_out | output | SP_W | Repaired stack pointer |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of the reset countdown. It carries inputs that would give a different trap and stack pointer. The bench raises this pulse a few cycles into the countdown and then checks three things: the first operation's results, the full countdown length, and that exactly one `done` occurs. The in-bounds and out-of-bounds edges of the stack pointer are also driven at STACK_SIZE and STACK_SIZE+1, for both the current and the starting value.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_PAGE  = 2'd1,
        TRAP_WPROT = 2'd2,
        TRAP_STACK = 2'd3
    } trap_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_FIN  = 2'd2
    } phase_e;
endpackage

// File: rtl/mfr_classify.sv
module mfr_classify
    import mfr_pkg::*;
#(
    parameter int STACK_SIZE = 14,
    parameter int SP_W       = $clog2(STACK_SIZE + 2)
) (
    input  logic            wp_bit,
    input  logic            dirty_bit,
    input  logic            was_store,
    input  logic            stk_over,
    input  logic            stk_under,
    input  logic [SP_W-1:0] cur_sp,
    output trap_e           code,
    output logic            is_stack
);
    localparam logic [SP_W-1:0] LIMIT = SP_W'(STACK_SIZE);

    logic sp_oob;
    logic wp_case;

    always_comb begin
        // out of bounds when sp - (size+1) is non-negative
        sp_oob   = (cur_sp > LIMIT);
        is_stack = stk_over | stk_under | sp_oob;
        wp_case  = wp_bit & ~dirty_bit & was_store;
        if (is_stack)     code = TRAP_STACK;
        else if (wp_case) code = TRAP_WPROT;
        else              code = TRAP_PAGE;
    end
endmodule

// File: rtl/mfr_sp_fix.sv
module mfr_sp_fix #(
    parameter int STACK_SIZE = 14,
    parameter int SP_W       = $clog2(STACK_SIZE + 2)
) (
    input  logic            is_stack,
    input  logic [SP_W-1:0] cur_sp,
    input  logic [SP_W-1:0] start_sp,
    output logic [SP_W-1:0] sp_fixed
);
    localparam logic [SP_W-1:0] LIMIT = SP_W'(STACK_SIZE);

    always_comb begin
        if (!is_stack)            sp_fixed = cur_sp;
        else if (start_sp > LIMIT) sp_fixed = LIMIT;
        else                      sp_fixed = start_sp;
    end
endmodule

// File: rtl/mfr_countdown.sv
module mfr_countdown #(
    parameter int CYCLES = 40,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active,
    output logic last
);
    localparam logic [CNT_W-1:0] INIT = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = INIT;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == CNT_W'(1));

    // R10
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);

    // R10
    count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mfr_top.sv
module mfr_top
    import mfr_pkg::*;
#(
    parameter int STACK_SIZE = 14,
    parameter int SP_W       = $clog2(STACK_SIZE + 2),
    parameter int VA_W       = 16,
    parameter int HI_KEEP    = 12,
    parameter int RST_CYCLES = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wp_bit,
    input  logic            dirty_bit,
    input  logic            was_store,
    input  logic            stk_over,
    input  logic            stk_under,
    input  logic [SP_W-1:0] cur_sp,
    input  logic [SP_W-1:0] start_sp,
    input  logic [VA_W-1:0] va_hi,
    input  logic [VA_W-1:0] va_lo,
    output logic            busy,
    output logic            done,
    output logic            fetch_rst,
    output logic [1:0]      trap_code,
    output logic [VA_W-1:0] param_lo,
    output logic [VA_W-1:0] param_hi,
    output logic [SP_W-1:0] sp_out
);
    localparam logic [VA_W-1:0] HI_MASK = VA_W'((64'd1 << HI_KEEP) - 64'd1);

    typedef struct packed {
        phase_e          phase;
        trap_e           code;
        logic [VA_W-1:0] plo;
        logic [VA_W-1:0] phi;
        logic [SP_W-1:0] sp;
    } state_t;

    state_t s_d, s_q;

    trap_e           cls_code;
    logic            cls_stack;
    logic [SP_W-1:0] sp_fixed;
    logic            accept;
    logic            cd_active, cd_last;

    mfr_classify #(.STACK_SIZE(STACK_SIZE), .SP_W(SP_W)) u_classify (
        .wp_bit(wp_bit), .dirty_bit(dirty_bit), .was_store(was_store),
        .stk_over(stk_over), .stk_under(stk_under), .cur_sp(cur_sp),
        .code(cls_code), .is_stack(cls_stack)
    );

    mfr_sp_fix #(.STACK_SIZE(STACK_SIZE), .SP_W(SP_W)) u_sp_fix (
        .is_stack(cls_stack), .cur_sp(cur_sp), .start_sp(start_sp),
        .sp_fixed(sp_fixed)
    );

    mfr_countdown #(.CYCLES(RST_CYCLES)) u_countdown (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .active(cd_active), .last(cd_last)
    );

    assign accept = start && (s_q.phase == ST_IDLE);

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            ST_IDLE: if (accept) begin
                s_d.phase = ST_HOLD;
                s_d.code  = cls_code;
                s_d.plo   = va_lo;
                s_d.phi   = va_hi & HI_MASK;
                s_d.sp    = sp_fixed;
            end
            ST_HOLD: if (cd_last) s_d.phase = ST_FIN;
            ST_FIN:  s_d.phase = ST_IDLE;
            default: s_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= ST_IDLE;
            s_q.code  <= TRAP_NONE;
            s_q.plo   <= '0;
            s_q.phi   <= '0;
            s_q.sp    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.phase != ST_IDLE);
    assign done      = (s_q.phase == ST_FIN);
    assign fetch_rst = cd_active;
    assign trap_code = s_q.code;
    assign param_lo  = s_q.plo;
    assign param_hi  = s_q.phi;
    assign sp_out    = s_q.sp;

    // R10
    done_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(fetch_rst) && !fetch_rst));

    // R10
    fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_rst) |-> done);

    // R11
    hold_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(trap_code) && $stable(sp_out)));

    // R7
    sp_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap_code == 2'd3) |-> (sp_out <= SP_W'(STACK_SIZE)));

    // R9
    hi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((param_hi & ~HI_MASK) == '0));
endmodule

// File: tb/test_mfr_top.sv
module test_mfr_top;
    localparam int CLK_PERIOD = 10;
    localparam int SZ   = 14;
    localparam int SPW  = 4;
    localparam int RSTC = 40;

    typedef struct packed {
        logic       wp, dirty, st, ovf, unf;
        logic [3:0] cur, init;
        logic [15:0] vh, vl;
        logic [1:0]  ecode;
        logic [3:0]  esp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 4'd5, 4'd2, 16'hF123, 16'hBEEF, 2'd2, 4'd5},  // R2
        '{1'b1,1'b1,1'b1,1'b0,1'b0, 4'd6, 4'd2, 16'hFFFF, 16'h0001, 2'd1, 4'd6},  // R3
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'd7, 4'd2, 16'h0ABC, 16'h1234, 2'd1, 4'd7},  // R3
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 4'd1, 4'd2, 16'hA000, 16'h0000, 2'd1, 4'd1},  // R3
        '{1'b1,1'b0,1'b1,1'b1,1'b0, 4'd5, 4'd3, 16'h5555, 16'hAAAA, 2'd3, 4'd3},  // R4 R6
        '{1'b0,1'b0,1'b0,1'b0,1'b1, 4'd2, 4'd15,16'h8FFF, 16'hFFFF, 2'd3, 4'd14}, // R4 R7
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 4'd15,4'd14,16'h1000, 16'h0F0F, 2'd3, 4'd14}, // R5 R6
        '{1'b0,1'b0,1'b0,1'b0,1'b0, 4'd14,4'd9, 16'h0FFF, 16'h7777, 2'd1, 4'd14}, // R5 R8
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 4'd0, 4'd0, 16'hC001, 16'h4321, 2'd3, 4'd0}   // R4 R6
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic wp_bit = 0, dirty_bit = 0, was_store = 0, stk_over = 0, stk_under = 0;
    logic [SPW-1:0] cur_sp = 0, start_sp = 0;
    logic [15:0] va_hi = 0, va_lo = 0;
    logic busy, done, fetch_rst;
    logic [1:0] trap_code;
    logic [15:0] param_lo, param_hi;
    logic [SPW-1:0] sp_out;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfr_top i_mfr_top (
        .clk(clk), .rst_n(rst_n), .start(start), .wp_bit(wp_bit),
        .dirty_bit(dirty_bit), .was_store(was_store), .stk_over(stk_over),
        .stk_under(stk_under), .cur_sp(cur_sp), .start_sp(start_sp),
        .va_hi(va_hi), .va_lo(va_lo), .busy(busy), .done(done),
        .fetch_rst(fetch_rst), .trap_code(trap_code), .param_lo(param_lo),
        .param_hi(param_hi), .sp_out(sp_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        wp_bit = v.wp; dirty_bit = v.dirty; was_store = v.st;
        stk_over = v.ovf; stk_under = v.unf;
        cur_sp = v.cur; start_sp = v.init; va_hi = v.vh; va_lo = v.vl;
    endtask

    // pulses start, returns fetch_rst cycle count until done; optional mid-run start
    task automatic run(input vec_t v, input bit poke, input vec_t other, output int rcount, output int ncycles);
        @(negedge clk);
        apply(v);
        start = 1;
        @(negedge clk);
        start = 0;
        rcount = 0; ncycles = 0;
        while (!done && ncycles < 200) begin
            if (fetch_rst) rcount++;
            ncycles++;
            if (poke && ncycles == 5) begin
                apply(other);
                start = 1;
            end else begin
                start = 0;
            end
            @(negedge clk);
        end
        start = 0;
    endtask

    initial begin
        int rc, nc;
        vec_t keep;
        repeat (3) @(negedge clk);
        // R1
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 fetch_rst", fetch_rst, 0);
        check("R1 trap_code", trap_code, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle after reset", busy, 0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], 0, VECS[i], rc, nc);
            check("R10 reset length", rc, RSTC);
            check("R10 done strobe", done, 1);
            check("R2 R3 R4 R5 trap_code", trap_code, VECS[i].ecode);
            check("R6 R7 R8 sp_out", sp_out, VECS[i].esp);
            check("R9 param_lo", param_lo, VECS[i].vl);
            check("R9 param_hi", param_hi, {4'h0, VECS[i].vh[11:0]});
            @(negedge clk);
            check("R10 done one cycle", done, 0);
        end

        // R11: second start mid-countdown with stack-error inputs
        run(VECS[0], 1, VECS[5], rc, nc);
        check("R11 reset length", rc, RSTC);
        check("R11 trap_code", trap_code, 2'd2);
        check("R11 sp_out", sp_out, 4'd5);
        check("R11 param_lo", param_lo, 16'hBEEF);
        @(negedge clk);
        check("R11 single done", done, 0);
        repeat (3) @(negedge clk);
        check("R11 stays idle", busy, 0);

        // R12: outputs hold while inputs change with no start
        keep = VECS[6];
        apply(keep);
        repeat (5) @(negedge clk);
        check("R12 trap_code held", trap_code, 2'd2);
        check("R12 sp_out held", sp_out, 4'd5);
        check("R12 param_hi held", param_hi, 16'h0123);
        check("R12 fetch_rst low", fetch_rst, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule